// File: doc/BRIEF.md
# Stream-to-memory write engine

The engine takes one command beat on a command stream. The command gives a start address, a byte count, a tag and two mode bits. The engine then takes byte-qualified data beats on a data stream and stores the bytes in an internal byte-addressable memory. When the transfer ends, for any reason, it returns one 8-bit status beat on a status stream. The status beat carries the command's tag and the outcome. Only one command is in flight at a time. A combinational peek port lets the surrounding logic or a bench read any byte of the memory.

The control state machine has three states. `ST_IDLE` accepts a command. `ST_MOVE` accepts data beats. `ST_REPORT` holds the status beat. The transitions are:
- *accept-good*: `ST_IDLE` to `ST_MOVE`, when a command is accepted with no error.
- *accept-bad*: `ST_IDLE` to `ST_REPORT`, when a command is accepted with a zero count or a decode error.
- *finish*: `ST_MOVE` to `ST_REPORT`, on the beat that ends the transfer, whether it ends normally or on an error.
- *retire*: `ST_REPORT` to `ST_IDLE`, when the status beat is taken.

Top module: `strm_mem_writer`

## Requirements
- R1: The command is one 104-bit beat with these fields:
  - bits [22:0]: byte count.
  - bit [23]: 1 selects incrementing addresses, 0 selects a fixed address.
  - bit [30]: end-of-frame expected.
  - bits [95:32]: 64-bit start address.
  - bits [99:96]: tag.
  - bits [31], [29:24] and [103:100]: ignored.
- R2: `cmd_tready` is high only in `ST_IDLE`. It stays low from the cycle after a command is accepted until the cycle after its status beat is taken.
- R3: `dat_tready` is low in every state except `ST_MOVE`. It is low before any command has been accepted.
- R4: In incrementing mode, accepted data beat n (counting from 0) writes byte lane i to address start + n*4 + i.
- R5: In fixed mode, every accepted beat writes its lanes to the start word, so the last beat's bytes remain there.
- R6: A lane is written only when its keep bit is high and the lane index is less than the number of bytes still owed. The owed count drops by the number of lanes written.
- R7: A transfer succeeds when the owed count reaches zero on a beat with TLAST, or, with end-of-frame clear, on any beat. With end-of-frame clear, TLAST before that point does not end the transfer. On success the status is 0x80 OR tag.
- R8: With end-of-frame set, TLAST on a beat that leaves bytes still owed ends the transfer. The status is 0x40 OR tag.
- R9: With end-of-frame set, if the owed count reaches zero on a beat without TLAST, `dat_tready` drops and the status is 0x40 OR tag.
- R10: A zero byte count gives status 0x10 OR tag. No data beat is accepted.
- R11: Any of the following gives status 0x20 OR tag, and no data beat is accepted:
  - a start address that is not a multiple of 4;
  - address bits above the memory size that are set;
  - an end address (start + count, or start + 4 in fixed mode) beyond the memory.
- R12: In the status beat, bits [3:0] carry the tag. Bit 7 is set only when bits [6:4] are clear. TLAST and TKEEP are 1. TVALID, together with stable data, stays high until `sts_tready`; the engine then returns to `ST_IDLE`.
- R13: Reset is synchronous and active low. While `rst_n` is low, all valid and ready outputs are low. A partial transfer is dropped, and the next command runs normally.
- R14: `peek_byte` shows, combinationally, the memory byte at `peek_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_tdata | input | 104 | Command word |
| cmd_tvalid | input | 1 | Command valid |
| cmd_tready | output | 1 | Command ready |
| dat_tdata | input | DATA_W | Data beat |
| dat_tkeep | input | DATA_W/8 | Byte-lane qualifiers |
| dat_tlast | input | 1 | Last beat of packet |
| dat_tvalid | input | 1 | Data valid |
| dat_tready | output | 1 | Data ready |
| sts_tdata | output | 8 | Status word |
| sts_tkeep | output | 1 | Status keep, always 1 |
| sts_tlast | output | 1 | Status last, always 1 |
| sts_tvalid | output | 1 | Status valid |
| sts_tready | input | 1 | Status ready |
| peek_addr | input | log2(MEM_BYTES) | Byte address to inspect |
| peek_byte | output | 8 | Byte at peek_addr |

## Verification
The table drives several kinds of transfer, and each one tells a different fault apart:
- Multi-beat incrementing packets check address stepping.
- A fixed-mode packet shows that the pointer holds still.
- A packet with end-of-frame clear shows that TLAST does not end the transfer early.
- Packets that are too short and too long separate the two slave-error paths.
- Zero-count, out-of-range and misaligned commands separate the internal-error path from the decode-error path. They also show that no data is taken.

A byte count that is not a multiple of the beat width, followed by a sparse-keep beat, shows that lanes are masked by both the owed count and TKEEP. Bytes that neighbour the written ones are read back to show they are untouched. A reset in the middle of a packet, followed by a fresh command, shows that the partial transfer is dropped.

// File: rtl/smw_pkg.sv
package smw_pkg;
    localparam int CMD_W   = 104;
    localparam int BTT_W   = 23;
    localparam int TAG_W   = 4;
    localparam int STS_W   = 8;
    localparam int STS_OK  = 7;
    localparam int STS_SLV = 6;
    localparam int STS_DEC = 5;
    localparam int STS_INT = 4;

    typedef struct packed {
        logic [3:0]       spare;
        logic [TAG_W-1:0] tag;
        logic [63:0]      start;
        logic             rsv_a;
        logic             eof;
        logic [5:0]       offs;
        logic             incr;
        logic [BTT_W-1:0] btt;
    } cmd_word_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_MOVE   = 2'd1,
        ST_REPORT = 2'd2
    } eng_state_t;
endpackage

// File: rtl/smw_cmd_decode.sv
module smw_cmd_decode
    import smw_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int MEM_BYTES = 1024
) (
    input  logic [CMD_W-1:0]  cmd_raw,
    output logic [TAG_W-1:0]  tag,
    output logic              eof,
    output logic              incr,
    output logic [BTT_W-1:0]  btt,
    output logic [$clog2(MEM_BYTES)-$clog2(DATA_W/8)-1:0] start_word,
    output logic              err_zero,
    output logic              err_range
);
    localparam int BPB     = DATA_W / 8;
    localparam int ADDR_W  = $clog2(MEM_BYTES);
    localparam int LANE_SH = $clog2(BPB);
    localparam int SUM_W   = ((ADDR_W > BTT_W) ? ADDR_W : BTT_W) + 1;

    cmd_word_t        c;
    logic             hi_set;
    logic             misalign;
    logic             over;
    logic [SUM_W-1:0] span;
    logic [SUM_W-1:0] end_b;
    logic             unused_fields;

    assign c = cmd_raw;

    assign tag        = c.tag;
    assign eof        = c.eof;
    assign incr       = c.incr;
    assign btt        = c.btt;
    assign start_word = c.start[ADDR_W-1:LANE_SH];

    always_comb begin
        hi_set   = |(c.start >> ADDR_W);
        misalign = (c.start[ADDR_W-1:0] & ADDR_W'(BPB - 1)) != '0;
        span     = c.incr ? SUM_W'(c.btt) : SUM_W'(BPB);
        end_b    = SUM_W'(c.start[ADDR_W-1:0]) + span;
        over     = end_b > SUM_W'(MEM_BYTES);
    end

    assign err_zero      = (c.btt == '0);
    assign err_range     = hi_set | misalign | over;
    assign unused_fields = ^{c.spare, c.rsv_a, c.offs};
endmodule

// File: rtl/smw_byte_mem.sv
module smw_byte_mem #(
    parameter int DATA_W    = 32,
    parameter int MEM_BYTES = 1024
) (
    input  logic                                          clk,
    input  logic [DATA_W/8-1:0]                           lane_we,
    input  logic [$clog2(MEM_BYTES)-$clog2(DATA_W/8)-1:0] wr_word,
    input  logic [DATA_W-1:0]                             wr_data,
    input  logic [$clog2(MEM_BYTES)-1:0]                  rd_addr,
    output logic [7:0]                                    rd_byte
);
    localparam int BPB     = DATA_W / 8;
    localparam int ADDR_W  = $clog2(MEM_BYTES);
    localparam int LANE_SH = $clog2(BPB);
    localparam int WORD_W  = ADDR_W - LANE_SH;
    localparam int WORDS   = MEM_BYTES / BPB;

    logic [7:0]        lane_q [BPB];
    logic [ADDR_W-1:0] rd_shift;
    logic [WORD_W-1:0] rd_word;
    logic              unused_hi;

    assign rd_shift  = rd_addr >> LANE_SH;
    assign rd_word   = rd_shift[WORD_W-1:0];
    assign unused_hi = ^rd_shift;

    for (genvar i = 0; i < BPB; i++) begin : g_lane
        logic [7:0] bank [WORDS];

        always_ff @(posedge clk) begin
            if (lane_we[i]) begin
                bank[wr_word] <= wr_data[i*8 +: 8];
            end
        end

        assign lane_q[i] = bank[rd_word];
    end

    always_comb begin
        rd_byte = lane_q[0];
        for (int i = 0; i < BPB; i++) begin
            if (ADDR_W'(i) == (rd_addr & ADDR_W'(BPB - 1))) begin
                rd_byte = lane_q[i];
            end
        end
    end
endmodule

// File: rtl/smw_ctrl.sv
module smw_ctrl
    import smw_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int MEM_BYTES = 1024
) (
    input  logic                                          clk,
    input  logic                                          rst_n,
    input  logic                                          cmd_tvalid,
    output logic                                          cmd_tready,
    input  logic [TAG_W-1:0]                              d_tag,
    input  logic                                          d_eof,
    input  logic                                          d_incr,
    input  logic [BTT_W-1:0]                              d_btt,
    input  logic [$clog2(MEM_BYTES)-$clog2(DATA_W/8)-1:0] d_word,
    input  logic                                          d_err_zero,
    input  logic                                          d_err_range,
    input  logic [DATA_W/8-1:0]                           dat_tkeep,
    input  logic                                          dat_tlast,
    input  logic                                          dat_tvalid,
    output logic                                          dat_tready,
    output logic [STS_W-1:0]                              sts_word,
    output logic                                          sts_tvalid,
    input  logic                                          sts_tready,
    output logic [DATA_W/8-1:0]                           lane_we,
    output logic [$clog2(MEM_BYTES)-$clog2(DATA_W/8)-1:0] wr_word
);
    localparam int BPB    = DATA_W / 8;
    localparam int WORD_W = $clog2(MEM_BYTES) - $clog2(BPB);
    localparam int CNT_W  = $clog2(BPB + 1);

    eng_state_t        state, state_nxt;
    logic [BTT_W-1:0]  rem;
    logic [BTT_W-1:0]  rem_nxt;
    logic [WORD_W-1:0] ptr;
    logic              incr_q;
    logic              eof_q;
    logic [STS_W-1:0]  sts_q;
    logic [CNT_W-1:0]  nwr;
    logic              take;
    logic              reached;
    logic              finish_ok;
    logic              finish_early;
    logic              finish_noend;
    logic              finish;
    logic              cmd_take;
    logic              cmd_bad;

    // Byte-lane masking and owed-byte arithmetic
    always_comb begin
        take = (state == ST_MOVE) && dat_tvalid;
        nwr  = '0;
        for (int i = 0; i < BPB; i++) begin
            lane_we[i] = take && dat_tkeep[i] && (BTT_W'(i) < rem);
            nwr        = nwr + CNT_W'(lane_we[i]);
        end
        rem_nxt      = rem - BTT_W'(nwr);
        reached      = (rem_nxt == '0);
        finish_ok    = take && reached && (dat_tlast || !eof_q);
        finish_early = take && eof_q && dat_tlast && !reached;
        finish_noend = take && eof_q && reached && !dat_tlast;
        finish       = finish_ok || finish_early || finish_noend;
        cmd_take     = (state == ST_IDLE) && cmd_tvalid;
        cmd_bad      = d_err_zero || d_err_range;
    end

    // Next-state selection
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:   if (cmd_tvalid) state_nxt = cmd_bad ? ST_REPORT : ST_MOVE;
            ST_MOVE:   if (finish)     state_nxt = ST_REPORT;
            ST_REPORT: if (sts_tready) state_nxt = ST_IDLE;
            default:                   state_nxt = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // Transfer context and status word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem    <= '0;
            ptr    <= '0;
            incr_q <= 1'b0;
            eof_q  <= 1'b0;
            sts_q  <= '0;
        end else if (cmd_take) begin
            rem             <= d_btt;
            ptr             <= d_word;
            incr_q          <= d_incr;
            eof_q           <= d_eof;
            sts_q           <= '0;
            sts_q[TAG_W-1:0] <= d_tag;
            sts_q[STS_INT]  <= d_err_zero;
            sts_q[STS_DEC]  <= d_err_range;
        end else if (take) begin
            rem <= rem_nxt;
            if (incr_q) ptr <= ptr + WORD_W'(1);
            if (finish) begin
                sts_q[STS_OK]  <= finish_ok;
                sts_q[STS_SLV] <= !finish_ok;
            end
        end
    end

    // Handshake outputs
    always_comb begin
        cmd_tready = rst_n && (state == ST_IDLE);
        dat_tready = rst_n && (state == ST_MOVE);
        sts_tvalid = rst_n && (state == ST_REPORT);
        sts_word   = sts_q;
        wr_word    = ptr;
    end

    // R2
    cmd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_tvalid && cmd_tready) |=> !cmd_tready);

    // R3
    data_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dat_tready |-> (!cmd_tready && !sts_tvalid));

    // R6
    owed_bytes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MOVE) |-> (BTT_W'(nwr) <= rem));

    // R9
    stop_noend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        finish_noend |=> (!dat_tready && sts_tvalid));

    // R12
    sts_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_tvalid && !sts_tready) |=> (sts_tvalid && $stable(sts_word)));

    // R12
    sts_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sts_tvalid |-> (sts_word[STS_OK] == (sts_word[STS_SLV:STS_INT] == 3'b000)));
endmodule

// File: rtl/strm_mem_writer.sv
module strm_mem_writer
    import smw_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int MEM_BYTES = 1024
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [103:0]                 cmd_tdata,
    input  logic                         cmd_tvalid,
    output logic                         cmd_tready,
    input  logic [DATA_W-1:0]            dat_tdata,
    input  logic [DATA_W/8-1:0]          dat_tkeep,
    input  logic                         dat_tlast,
    input  logic                         dat_tvalid,
    output logic                         dat_tready,
    output logic [7:0]                   sts_tdata,
    output logic [0:0]                   sts_tkeep,
    output logic                         sts_tlast,
    output logic                         sts_tvalid,
    input  logic                         sts_tready,
    input  logic [$clog2(MEM_BYTES)-1:0] peek_addr,
    output logic [7:0]                   peek_byte
);
    localparam int BPB    = DATA_W / 8;
    localparam int WORD_W = $clog2(MEM_BYTES) - $clog2(BPB);

    logic [TAG_W-1:0]  d_tag;
    logic              d_eof;
    logic              d_incr;
    logic [BTT_W-1:0]  d_btt;
    logic [WORD_W-1:0] d_word;
    logic              d_err_zero;
    logic              d_err_range;
    logic [BPB-1:0]    lane_we;
    logic [WORD_W-1:0] wr_word;

    smw_cmd_decode #(.DATA_W(DATA_W), .MEM_BYTES(MEM_BYTES)) u_dec (
        .cmd_raw    (cmd_tdata),
        .tag        (d_tag),
        .eof        (d_eof),
        .incr       (d_incr),
        .btt        (d_btt),
        .start_word (d_word),
        .err_zero   (d_err_zero),
        .err_range  (d_err_range)
    );

    smw_ctrl #(.DATA_W(DATA_W), .MEM_BYTES(MEM_BYTES)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_tvalid  (cmd_tvalid),
        .cmd_tready  (cmd_tready),
        .d_tag       (d_tag),
        .d_eof       (d_eof),
        .d_incr      (d_incr),
        .d_btt       (d_btt),
        .d_word      (d_word),
        .d_err_zero  (d_err_zero),
        .d_err_range (d_err_range),
        .dat_tkeep   (dat_tkeep),
        .dat_tlast   (dat_tlast),
        .dat_tvalid  (dat_tvalid),
        .dat_tready  (dat_tready),
        .sts_word    (sts_tdata),
        .sts_tvalid  (sts_tvalid),
        .sts_tready  (sts_tready),
        .lane_we     (lane_we),
        .wr_word     (wr_word)
    );

    smw_byte_mem #(.DATA_W(DATA_W), .MEM_BYTES(MEM_BYTES)) u_mem (
        .clk     (clk),
        .lane_we (lane_we),
        .wr_word (wr_word),
        .wr_data (dat_tdata),
        .rd_addr (peek_addr),
        .rd_byte (peek_byte)
    );

    assign sts_tkeep = 1'b1;
    assign sts_tlast = 1'b1;

    // R10
    no_data_on_bad_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_tvalid && cmd_tready && (d_err_zero || d_err_range)) |=> (sts_tvalid && !dat_tready));
endmodule

// File: tb/test_strm_mem_writer.sv
module test_strm_mem_writer;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [103:0] cmd_tdata = '0;
    logic         cmd_tvalid = 1'b0;
    logic         cmd_tready;
    logic [31:0]  dat_tdata = '0;
    logic [3:0]   dat_tkeep = '0;
    logic         dat_tlast = 1'b0;
    logic         dat_tvalid = 1'b0;
    logic         dat_tready;
    logic [7:0]   sts_tdata;
    logic [0:0]   sts_tkeep;
    logic         sts_tlast;
    logic         sts_tvalid;
    logic         sts_tready = 1'b0;
    logic [9:0]   peek_addr = '0;
    logic [7:0]   peek_byte;

    int total = 0;
    int fails = 0;
    int cyc = 0;

    strm_mem_writer i_strm_mem_writer (.*);

    always #4 clk = ~clk;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            total++;
            fails++;
            $display("FAIL R2 watchdog act=hung exp=finished");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    typedef struct packed {
        logic [15:0] addr;
        logic [15:0] btt;
        logic [3:0]  tag;
        logic        eof;
        logic        incr;
        logic [7:0]  nb;
        logic [7:0]  exp_sts;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{16'h000, 16'd64, 4'd1,  1'b1, 1'b1, 8'd16, 8'h81},
        '{16'h100, 16'd12, 4'd2,  1'b0, 1'b1, 8'd3,  8'h82},
        '{16'h200, 16'd16, 4'd3,  1'b1, 1'b0, 8'd4,  8'h83},
        '{16'h040, 16'd8,  4'd4,  1'b1, 1'b1, 8'd4,  8'h44},
        '{16'h080, 16'd16, 4'd5,  1'b1, 1'b1, 8'd2,  8'h45},
        '{16'h000, 16'd0,  4'd6,  1'b1, 1'b1, 8'd0,  8'h16},
        '{16'h3F0, 16'd32, 4'd7,  1'b1, 1'b1, 8'd0,  8'h27},
        '{16'h102, 16'd4,  4'd8,  1'b1, 1'b1, 8'd0,  8'h28},
        '{16'h300, 16'd8,  4'd9,  1'b1, 1'b1, 8'd2,  8'h89},
        '{16'h300, 16'd6,  4'd10, 1'b1, 1'b1, 8'd2,  8'h8A},
        '{16'h340, 16'd4,  4'd11, 1'b1, 1'b1, 8'd1,  8'h8B}
    };

    function automatic logic [7:0] pat(int s, int k);
        return 8'(s * 29 + k * 7 + 3);
    endfunction

    function automatic logic [103:0] mk_cmd(logic [63:0] a, logic [22:0] n,
                                            logic [3:0] t, logic e, logic inc);
        return {4'h0, t, a, 1'b0, e, 6'd0, inc, n};
    endfunction

    function automatic string req_of(logic [7:0] s);
        if (s[7]) return "R7";
        if (s[6]) return "R8 R9";
        if (s[5]) return "R11";
        return "R10";
    endfunction

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic peek(logic [9:0] a, output logic [7:0] b);
        peek_addr = a;
        #1;
        b = peek_byte;
    endtask

    task automatic send_cmd(logic [103:0] w);
        int n = 0;
        @(negedge clk);
        chk("R3 gate before cmd", dat_tready, 0);
        cmd_tdata  = w;
        cmd_tvalid = 1'b1;
        while (!cmd_tready && n < 100) begin
            @(negedge clk);
            n++;
        end
        @(posedge clk);
        @(negedge clk);
        cmd_tvalid = 1'b0;
        chk("R2 busy after cmd", cmd_tready, 0);
    endtask

    task automatic send_beat(logic [31:0] d, logic [3:0] k, logic l, output bit taken);
        int n = 0;
        taken      = 1'b0;
        dat_tdata  = d;
        dat_tkeep  = k;
        dat_tlast  = l;
        dat_tvalid = 1'b1;
        while (n < 100) begin
            if (dat_tready) begin
                @(posedge clk);
                taken = 1'b1;
                @(negedge clk);
                break;
            end
            if (sts_tvalid) break;
            @(negedge clk);
            n++;
        end
        dat_tvalid = 1'b0;
        dat_tlast  = 1'b0;
    endtask

    task automatic recv_sts(output logic [7:0] s);
        int n = 0;
        sts_tready = 1'b0;
        while (!sts_tvalid && n < 100) begin
            @(negedge clk);
            n++;
        end
        s = sts_tdata;
        @(negedge clk);
        @(negedge clk);
        chk("R12 status held valid", sts_tvalid, 1);
        chk("R12 status held data", sts_tdata, s);
        chk("R12 status last/keep", {sts_tlast, sts_tkeep}, 2'b11);
        sts_tready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        sts_tready = 1'b0;
        chk("R12 back to idle", cmd_tready, 1);
    endtask

    initial begin
        logic [7:0]  s;
        logic [7:0]  b;
        logic [31:0] d;
        bit          tk;
        int          wcount;

        repeat (3) @(negedge clk);
        chk("R13 outputs low in reset", {cmd_tready, dat_tready, sts_tvalid}, 3'b000);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R2 idle ready after reset", cmd_tready, 1);
        chk("R3 no data ready after reset", dat_tready, 0);

        // Table of transfers
        for (int v = 0; v < NV; v++) begin
            send_cmd(mk_cmd(64'(VECS[v].addr), 23'(VECS[v].btt), VECS[v].tag,
                            VECS[v].eof, VECS[v].incr));
            for (int bt = 0; bt < int'(VECS[v].nb); bt++) begin
                for (int i = 0; i < 4; i++) d[i*8 +: 8] = pat(v, bt * 4 + i);
                send_beat(d, 4'hF, bt == int'(VECS[v].nb) - 1, tk);
                if (!tk) break;
            end
            recv_sts(s);
            chk($sformatf("%s R1 status vec %0d", req_of(VECS[v].exp_sts), v), s, VECS[v].exp_sts);
            if (VECS[v].incr) begin
                wcount = int'(VECS[v].btt);
                if (wcount > int'(VECS[v].nb) * 4) wcount = int'(VECS[v].nb) * 4;
                for (int k = 0; k < wcount; k++) begin
                    peek(10'(VECS[v].addr + 16'(k)), b);
                    chk($sformatf("R4 R6 R14 byte vec %0d k %0d", v, k), b, pat(v, k));
                end
            end else begin
                for (int i = 0; i < 4; i++) begin
                    peek(10'(VECS[v].addr + 16'(i)), b);
                    chk($sformatf("R5 fixed word lane %0d", i), b,
                        pat(v, (int'(VECS[v].nb) - 1) * 4 + i));
                end
            end
        end

        // Bytes beyond a 6-byte count were left from the earlier 8-byte write
        peek(10'h306, b);
        chk("R6 owed-count mask 0x306", b, pat(8, 6));
        peek(10'h307, b);
        chk("R6 owed-count mask 0x307", b, pat(8, 7));

        // Sparse keep with early TLAST: only lane 1 is both kept and owed
        @(negedge clk);
        send_cmd(mk_cmd(64'h340, 23'd2, 4'd12, 1'b1, 1'b1));
        send_beat(32'hDDCCBBAA, 4'b1010, 1'b1, tk);
        recv_sts(s);
        chk("R8 early last status", s, 8'h4C);
        peek(10'h340, b);
        chk("R6 keep-low lane 0", b, pat(10, 0));
        peek(10'h341, b);
        chk("R6 kept owed lane 1", b, 8'hBB);
        peek(10'h342, b);
        chk("R6 keep-low lane 2", b, pat(10, 2));
        peek(10'h343, b);
        chk("R6 kept but not owed lane 3", b, pat(10, 3));

        // TLAST before the count is reached, with end-of-frame clear
        send_cmd(mk_cmd(64'h3A0, 23'd8, 4'd13, 1'b0, 1'b1));
        send_beat(32'h44332211, 4'hF, 1'b1, tk);
        @(negedge clk);
        chk("R7 tlast ignored without eof", {dat_tready, sts_tvalid}, 2'b10);
        send_beat(32'h88776655, 4'hF, 1'b0, tk);
        recv_sts(s);
        chk("R7 eof-clear completion", s, 8'h8D);
        peek(10'h3A7, b);
        chk("R4 eof-clear last byte", b, 8'h88);

        // Reset in the middle of a packet
        send_cmd(mk_cmd(64'h380, 23'd16, 4'd14, 1'b1, 1'b1));
        send_beat(32'h01020304, 4'hF, 1'b0, tk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R13 outputs low mid-reset", {cmd_tready, dat_tready, sts_tvalid}, 3'b000);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R13 idle after reset", {cmd_tready, dat_tready, sts_tvalid}, 3'b100);
        send_cmd(mk_cmd(64'h380, 23'd4, 4'd15, 1'b1, 1'b1));
        send_beat(32'hCAFEF00D, 4'hF, 1'b1, tk);
        recv_sts(s);
        chk("R13 fresh command after reset", s, 8'h8F);
        peek(10'h383, b);
        chk("R14 peek after reset", b, 8'hCA);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule